// File: doc/BRIEF.md
# Thread-Aware Speculative Way Predictor

This block predicts, early in a load, which way of a two-thread shared data cache holds the requested line. Each way of each set keeps a valid flag, a short partial tag taken from the linear address, and the ID of the hardware thread that filled it. A lookup presents a linear address and a thread ID. One cycle later the block returns a speculative hit flag and the predicted way. The full tag compare, the data array, replacement and miss handling belong to neighbouring logic.

Whether the owner-thread compare applies depends on a global mode bit and on a same-context bit. A context unit keeps a page-table base value and a paging-mode code for each thread. Each write to either thread's context recomputes the same-context bit. When both threads translate through identical structures in adaptive mode, a line filled by one thread can be predicted for the other. In shared mode, or when the contexts differ, a thread only hits on lines it filled.

Top module: `thread_way_predictor`

## Requirements
- R1: After reset no entry is valid, the mode bit is 0 (adaptive), both threads' page-table base and paging mode are zero, same_ctx is 1, and rsp_valid and rsp_hit are 0.
- R2: rsp_valid is 1 in exactly the cycle after a cycle with lkp_valid high. rsp_hit is 0 whenever rsp_valid is 0.
- R3: A lookup uses linear-address bits 10..6 as the set index and bits 15..11 as the partial tag. A way can only hit if it is valid in that set and its stored partial tag equals the lookup's partial tag.
- R4: In shared mode (mode bit 1), a hit also requires the way's owner ID to equal lkp_thread.
- R5: In adaptive mode (mode bit 0) with same_ctx at 1, the owner ID is ignored and any valid way with a matching tag qualifies.
- R6: In adaptive mode with same_ctx at 0, the owner ID must equal lkp_thread, as in shared mode.
- R7: same_ctx is 1 exactly when both threads' base values are equal and both paging-mode codes are equal. It is recomputed on every context write and takes the new value in the cycle after the write. Without a context write it holds its value. A lookup issued in the same cycle as a context write uses the old value.
- R8: When several ways qualify, rsp_way is the lowest-numbered one. On a miss, rsp_way is 0.
- R9: A fill sets valid, partial tag and owner ID for a given set and way. An invalidate clears the valid flag of a given set and way. When both target the same entry in one cycle, the entry ends up invalid.
- R10: A lookup in the same cycle as a fill to its set sees the contents from before the fill.
- R11: A mode write takes effect in the cycle after it. A lookup issued in the same cycle as a mode write uses the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_addr | input | ADDR_W | Linear address of the lookup |
| lkp_thread | input | 1 | Thread ID of the lookup |
| fill_en | input | 1 | Fill request |
| fill_set | input | SET_BITS | Set written by the fill |
| fill_way | input | WAY_W | Way written by the fill |
| fill_tag | input | TAG_BITS | Partial tag stored by the fill |
| fill_thread | input | 1 | Owner ID stored by the fill |
| inv_en | input | 1 | Invalidate request |
| inv_set | input | SET_BITS | Set of the entry to invalidate |
| inv_way | input | WAY_W | Way of the entry to invalidate |
| ctx_wr_en | input | 1 | Context write strobe |
| ctx_wr_thread | input | 1 | Thread whose context is written |
| ctx_wr_base | input | BASE_W | New page-table base value |
| ctx_wr_pmode | input | PMODE_W | New paging-mode code |
| mode_wr_en | input | 1 | Mode bit write strobe |
| mode_wr_val | input | 1 | New mode bit (0 adaptive, 1 shared) |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Speculative hit |
| rsp_way | output | WAY_W | Predicted way |
| same_ctx | output | 1 | Both threads share translation context |

## Verification
A lookup result is due exactly one clock edge after the lookup is captured. Writes to context, mode or array state take effect at their capturing edge, so the next lookup sees them and a lookup captured at the same edge does not. The driver changes inputs just after a rising edge and queues each lookup's expected result at that moment. The monitor compares on the falling edge, one cycle later, and flags any response the queue did not expect. The same_ctx output is checked on the cycle right after a context write completes. Combined-cycle cases (fill with lookup, context write with lookup, mode write with lookup) are driven together so the old-value rule can be observed.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic {
        MODE_ADAPTIVE = 1'b0,
        MODE_SHARED   = 1'b1
    } wp_mode_e;

    localparam int unsigned WP_THREADS = 2;

endpackage

// File: rtl/wp_context_unit.sv
module wp_context_unit
    import wp_pkg::*;
#(
    parameter int unsigned BASE_W  = 32,
    parameter int unsigned PMODE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_thread,
    input  logic [BASE_W-1:0]  wr_base,
    input  logic [PMODE_W-1:0] wr_pmode,
    input  logic               mode_wr_en,
    input  logic               mode_wr_val,
    output wp_mode_e           mode,
    output logic               same_ctx
);

    typedef struct packed {
        logic [WP_THREADS-1:0][BASE_W-1:0]  base;
        logic [WP_THREADS-1:0][PMODE_W-1:0] pmode;
        wp_mode_e                           mode;
        logic                               same;
    } ctx_state_t;

    ctx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.base[wr_thread]  = wr_base;
            st_d.pmode[wr_thread] = wr_pmode;
            st_d.same = (st_d.base[0] == st_d.base[1]) &&
                        (st_d.pmode[0] == st_d.pmode[1]);
        end
        if (mode_wr_en) begin
            st_d.mode = wp_mode_e'(mode_wr_val);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.base  <= '0;
            st_q.pmode <= '0;
            st_q.mode  <= MODE_ADAPTIVE;
            st_q.same  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode     = st_q.mode;
    assign same_ctx = st_q.same;

endmodule

// File: rtl/wp_tag_array.sv
module wp_tag_array #(
    parameter int unsigned SET_BITS = 5,
    parameter int unsigned WAYS     = 4,
    parameter int unsigned TAG_BITS = 5,
    localparam int unsigned SETS    = 1 << SET_BITS,
    localparam int unsigned WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fill_en,
    input  logic [SET_BITS-1:0]           fill_set,
    input  logic [WAY_W-1:0]              fill_way,
    input  logic [TAG_BITS-1:0]           fill_tag,
    input  logic                          fill_thread,
    input  logic                          inv_en,
    input  logic [SET_BITS-1:0]           inv_set,
    input  logic [WAY_W-1:0]              inv_way,
    input  logic [SET_BITS-1:0]           rd_set,
    output logic [WAYS-1:0]               rd_valid,
    output logic [WAYS-1:0][TAG_BITS-1:0] rd_tag,
    output logic [WAYS-1:0]               rd_owner
);

    typedef struct packed {
        logic                valid;
        logic [TAG_BITS-1:0] tag;
        logic                owner;
    } entry_t;

    entry_t [SETS-1:0][WAYS-1:0] ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (fill_en) begin
            ent_d[fill_set][fill_way].valid = 1'b1;
            ent_d[fill_set][fill_way].tag   = fill_tag;
            ent_d[fill_set][fill_way].owner = fill_thread;
        end
        if (inv_en) begin
            ent_d[inv_set][inv_way].valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_read
        assign rd_valid[w] = ent_q[rd_set][w].valid;
        assign rd_tag[w]   = ent_q[rd_set][w].tag;
        assign rd_owner[w] = ent_q[rd_set][w].owner;
    end

endmodule

// File: rtl/wp_way_select.sv
module wp_way_select #(
    parameter int unsigned WAYS     = 4,
    parameter int unsigned TAG_BITS = 5,
    localparam int unsigned WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]               way_valid,
    input  logic [WAYS-1:0][TAG_BITS-1:0] way_tag,
    input  logic [WAYS-1:0]               way_owner,
    input  logic [TAG_BITS-1:0]           look_tag,
    input  logic                          look_thread,
    input  logic                          ignore_owner,
    output logic                          any_hit,
    output logic [WAY_W-1:0]              hit_way
);

    logic [WAYS-1:0] qual;

    for (genvar w = 0; w < WAYS; w++) begin : g_qual
        assign qual[w] = way_valid[w] &&
                         (way_tag[w] == look_tag) &&
                         (ignore_owner || (way_owner[w] == look_thread));
    end

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (qual[w]) begin
                hit_way = WAY_W'(w);
            end
        end
    end

    assign any_hit = |qual;

endmodule

// File: rtl/thread_way_predictor.sv
module thread_way_predictor
    import wp_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned SET_BITS = 5,
    parameter int unsigned SET_LSB  = 6,
    parameter int unsigned TAG_BITS = 5,
    parameter int unsigned WAYS     = 4,
    parameter int unsigned BASE_W   = 32,
    parameter int unsigned PMODE_W  = 2,
    localparam int unsigned TAG_LSB = SET_LSB + SET_BITS,
    localparam int unsigned TAG_MSB = TAG_LSB + TAG_BITS - 1,
    localparam int unsigned WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lkp_valid,
    input  logic [ADDR_W-1:0]   lkp_addr,
    input  logic                lkp_thread,
    input  logic                fill_en,
    input  logic [SET_BITS-1:0] fill_set,
    input  logic [WAY_W-1:0]    fill_way,
    input  logic [TAG_BITS-1:0] fill_tag,
    input  logic                fill_thread,
    input  logic                inv_en,
    input  logic [SET_BITS-1:0] inv_set,
    input  logic [WAY_W-1:0]    inv_way,
    input  logic                ctx_wr_en,
    input  logic                ctx_wr_thread,
    input  logic [BASE_W-1:0]   ctx_wr_base,
    input  logic [PMODE_W-1:0]  ctx_wr_pmode,
    input  logic                mode_wr_en,
    input  logic                mode_wr_val,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [WAY_W-1:0]    rsp_way,
    output logic                same_ctx
);

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic [WAY_W-1:0] way;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    wp_mode_e                      cur_mode;
    logic                          cur_same;
    logic [SET_BITS-1:0]           look_set;
    logic [TAG_BITS-1:0]           look_tag;
    logic [WAYS-1:0]               arr_valid;
    logic [WAYS-1:0][TAG_BITS-1:0] arr_tag;
    logic [WAYS-1:0]               arr_owner;
    logic                          sel_hit;
    logic [WAY_W-1:0]              sel_way;
    logic                          owner_free;
    logic                          unused_addr_bits;

    assign look_set = lkp_addr[TAG_LSB-1:SET_LSB];
    assign look_tag = lkp_addr[TAG_MSB:TAG_LSB];
    assign unused_addr_bits = ^{lkp_addr[ADDR_W-1:TAG_MSB+1], lkp_addr[SET_LSB-1:0]};

    wp_context_unit #(
        .BASE_W  (BASE_W),
        .PMODE_W (PMODE_W)
    ) u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (ctx_wr_en),
        .wr_thread   (ctx_wr_thread),
        .wr_base     (ctx_wr_base),
        .wr_pmode    (ctx_wr_pmode),
        .mode_wr_en  (mode_wr_en),
        .mode_wr_val (mode_wr_val),
        .mode        (cur_mode),
        .same_ctx    (cur_same)
    );

    wp_tag_array #(
        .SET_BITS (SET_BITS),
        .WAYS     (WAYS),
        .TAG_BITS (TAG_BITS)
    ) u_arr (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill_en     (fill_en),
        .fill_set    (fill_set),
        .fill_way    (fill_way),
        .fill_tag    (fill_tag),
        .fill_thread (fill_thread),
        .inv_en      (inv_en),
        .inv_set     (inv_set),
        .inv_way     (inv_way),
        .rd_set      (look_set),
        .rd_valid    (arr_valid),
        .rd_tag      (arr_tag),
        .rd_owner    (arr_owner)
    );

    assign owner_free = (cur_mode == MODE_ADAPTIVE) && cur_same;

    wp_way_select #(
        .WAYS     (WAYS),
        .TAG_BITS (TAG_BITS)
    ) u_sel (
        .way_valid    (arr_valid),
        .way_tag      (arr_tag),
        .way_owner    (arr_owner),
        .look_tag     (look_tag),
        .look_thread  (lkp_thread),
        .ignore_owner (owner_free),
        .any_hit      (sel_hit),
        .hit_way      (sel_way)
    );

    always_comb begin
        rsp_d.valid = lkp_valid;
        rsp_d.hit   = lkp_valid && sel_hit;
        rsp_d.way   = (lkp_valid && sel_hit) ? sel_way : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_way   = rsp_q.way;
    assign same_ctx  = cur_same;

endmodule

// File: rtl/wp_checker.sv
module wp_checker #(
    parameter int unsigned WAY_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lkp_valid,
    input logic             ctx_wr_en,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [WAY_W-1:0] rsp_way,
    input logic             same_ctx
);

    // R2
    rsp_follows_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_valid |=> !rsp_valid);

    // R2
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_hit);

    // R8
    miss_way_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_way == '0));

    // R7
    ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctx_wr_en |=> $stable(same_ctx));

endmodule

bind thread_way_predictor wp_checker #(.WAY_W(WAY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lkp_valid (lkp_valid),
    .ctx_wr_en (ctx_wr_en),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_way   (rsp_way),
    .same_ctx  (same_ctx)
);

// File: tb/tb_thread_way_predictor.sv
module tb_thread_way_predictor;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lkp_valid, lkp_thread;
    logic [31:0] lkp_addr;
    logic        fill_en, fill_thread;
    logic [4:0]  fill_set, fill_tag;
    logic [1:0]  fill_way;
    logic        inv_en;
    logic [4:0]  inv_set;
    logic [1:0]  inv_way;
    logic        ctx_wr_en, ctx_wr_thread;
    logic [31:0] ctx_wr_base;
    logic [1:0]  ctx_wr_pmode;
    logic        mode_wr_en, mode_wr_val;
    logic        rsp_valid, rsp_hit, same_ctx;
    logic [1:0]  rsp_way;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct {
        logic       hit;
        logic [1:0] way;
        string      req;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    thread_way_predictor dut (
        .clk(clk), .rst_n(rst_n),
        .lkp_valid(lkp_valid), .lkp_addr(lkp_addr), .lkp_thread(lkp_thread),
        .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
        .fill_tag(fill_tag), .fill_thread(fill_thread),
        .inv_en(inv_en), .inv_set(inv_set), .inv_way(inv_way),
        .ctx_wr_en(ctx_wr_en), .ctx_wr_thread(ctx_wr_thread),
        .ctx_wr_base(ctx_wr_base), .ctx_wr_pmode(ctx_wr_pmode),
        .mode_wr_en(mode_wr_en), .mode_wr_val(mode_wr_val),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .same_ctx(same_ctx)
    );

    function automatic logic [31:0] mk_addr(input logic [4:0] tag, input logic [4:0] set);
        return {16'h0000, tag, set, 6'h2a};
    endfunction

    task automatic check(input string req, input int act, input int exp_v, input string what);
        n_checks++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Stage a lookup on the current cycle; caller ticks.
    task automatic stage_lookup(input logic [4:0] tag, input logic [4:0] set, input logic thr,
                                input logic e_hit, input logic [1:0] e_way, input string req);
        exp_t e;
        e.hit = e_hit; e.way = e_way; e.req = req;
        exp_q.push_back(e);
        lkp_valid  = 1'b1;
        lkp_addr   = mk_addr(tag, set);
        lkp_thread = thr;
    endtask

    task automatic lookup(input logic [4:0] tag, input logic [4:0] set, input logic thr,
                          input logic e_hit, input logic [1:0] e_way, input string req);
        stage_lookup(tag, set, thr, e_hit, e_way, req);
        tick();
        lkp_valid = 1'b0;
    endtask

    task automatic stage_fill(input logic [4:0] set, input logic [1:0] way,
                              input logic [4:0] tag, input logic thr);
        fill_en = 1'b1; fill_set = set; fill_way = way; fill_tag = tag; fill_thread = thr;
    endtask

    task automatic fill(input logic [4:0] set, input logic [1:0] way,
                        input logic [4:0] tag, input logic thr);
        stage_fill(set, way, tag, thr);
        tick();
        fill_en = 1'b0;
    endtask

    task automatic invalidate(input logic [4:0] set, input logic [1:0] way);
        inv_en = 1'b1; inv_set = set; inv_way = way;
        tick();
        inv_en = 1'b0;
    endtask

    task automatic stage_ctx(input logic thr, input logic [31:0] base, input logic [1:0] pm);
        ctx_wr_en = 1'b1; ctx_wr_thread = thr; ctx_wr_base = base; ctx_wr_pmode = pm;
    endtask

    task automatic ctx_write(input logic thr, input logic [31:0] base, input logic [1:0] pm);
        stage_ctx(thr, base, pm);
        tick();
        ctx_wr_en = 1'b0;
    endtask

    task automatic set_mode(input logic v);
        mode_wr_en = 1'b1; mode_wr_val = v;
        tick();
        mode_wr_en = 1'b0;
    endtask

    // Monitor: compare each response against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check("R2", 1, 0, "unexpected rsp_valid");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.req, int'(rsp_hit), int'(e.hit), "rsp_hit");
                    check(e.req, int'(rsp_way), int'(e.way), "rsp_way");
                end
            end else begin
                if (rsp_hit) check("R2", 1, 0, "rsp_hit without rsp_valid");
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        lkp_valid = 0; lkp_addr = '0; lkp_thread = 0;
        fill_en = 0; fill_set = '0; fill_way = '0; fill_tag = '0; fill_thread = 0;
        inv_en = 0; inv_set = '0; inv_way = '0;
        ctx_wr_en = 0; ctx_wr_thread = 0; ctx_wr_base = '0; ctx_wr_pmode = '0;
        mode_wr_en = 0; mode_wr_val = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check("R1", int'(rsp_valid), 0, "rsp_valid after reset");
        check("R1", int'(rsp_hit), 0, "rsp_hit after reset");
        check("R1", int'(same_ctx), 1, "same_ctx after reset");

        // R1 / R8: every entry invalid -> miss with way 0
        lookup(5'd5, 5'd3, 1'b0, 1'b0, 2'd0, "R1");

        // R3 / R9: fill then hit
        fill(5'd3, 2'd2, 5'd5, 1'b0);
        lookup(5'd5, 5'd3, 1'b0, 1'b1, 2'd2, "R9");
        // R5 (and R1 adaptive reset mode): other thread hits too
        lookup(5'd5, 5'd3, 1'b1, 1'b1, 2'd2, "R5");
        // R3: tag mismatch and set mismatch miss
        lookup(5'd6, 5'd3, 1'b0, 1'b0, 2'd0, "R3");
        lookup(5'd5, 5'd4, 1'b0, 1'b0, 2'd0, "R3");

        // R4 shared mode
        set_mode(1'b1);
        lookup(5'd5, 5'd3, 1'b1, 1'b0, 2'd0, "R4");
        lookup(5'd5, 5'd3, 1'b0, 1'b1, 2'd2, "R4");
        fill(5'd3, 2'd1, 5'd5, 1'b1);
        lookup(5'd5, 5'd3, 1'b1, 1'b1, 2'd1, "R4");
        lookup(5'd5, 5'd3, 1'b0, 1'b1, 2'd2, "R4");

        // R8: adaptive, same context, both ways qualify -> lowest
        set_mode(1'b0);
        lookup(5'd5, 5'd3, 1'b0, 1'b1, 2'd1, "R8");

        // R7 / R6: diverging context
        ctx_write(1'b1, 32'h0000_1000, 2'd0);
        check("R7", int'(same_ctx), 0, "same_ctx base differs");
        lookup(5'd5, 5'd3, 1'b0, 1'b1, 2'd2, "R6");
        lookup(5'd5, 5'd3, 1'b1, 1'b1, 2'd1, "R6");
        ctx_write(1'b0, 32'h0000_1000, 2'd0);
        check("R7", int'(same_ctx), 1, "same_ctx bases equal");
        ctx_write(1'b0, 32'h0000_1000, 2'd1);
        check("R7", int'(same_ctx), 0, "same_ctx pmode differs");
        ctx_write(1'b1, 32'h0000_1000, 2'd1);
        check("R7", int'(same_ctx), 1, "same_ctx all equal");

        // R7: lookup in the cycle of a context write uses old same_ctx
        stage_ctx(1'b1, 32'h0000_2000, 2'd1);
        stage_lookup(5'd5, 5'd3, 1'b0, 1'b1, 2'd1, "R7");
        tick();
        ctx_wr_en = 1'b0; lkp_valid = 1'b0;
        check("R7", int'(same_ctx), 0, "same_ctx after combined write");
        lookup(5'd5, 5'd3, 1'b0, 1'b1, 2'd2, "R7");

        // R9: invalidate removes thread 1's way
        invalidate(5'd3, 2'd1);
        lookup(5'd5, 5'd3, 1'b1, 1'b0, 2'd0, "R9");

        // R10: fill and lookup to same set in one cycle sees old contents
        stage_fill(5'd3, 2'd0, 5'd5, 1'b1);
        stage_lookup(5'd5, 5'd3, 1'b1, 1'b0, 2'd0, "R10");
        tick();
        fill_en = 1'b0; lkp_valid = 1'b0;
        lookup(5'd5, 5'd3, 1'b1, 1'b1, 2'd0, "R10");

        // R9: fill and invalidate to the same entry -> invalid
        stage_fill(5'd7, 2'd3, 5'd9, 1'b0);
        inv_en = 1'b1; inv_set = 5'd7; inv_way = 2'd3;
        tick();
        fill_en = 1'b0; inv_en = 1'b0;
        lookup(5'd9, 5'd7, 1'b0, 1'b0, 2'd0, "R9");

        // R11: mode write with a lookup in the same cycle uses old mode
        ctx_write(1'b1, 32'h0000_1000, 2'd1);
        check("R7", int'(same_ctx), 1, "same_ctx restored");
        mode_wr_en = 1'b1; mode_wr_val = 1'b1;
        stage_lookup(5'd5, 5'd3, 1'b0, 1'b1, 2'd0, "R11");
        tick();
        mode_wr_en = 1'b0; lkp_valid = 1'b0;
        lookup(5'd5, 5'd3, 1'b0, 1'b1, 2'd2, "R11");

        // Drain and idle check
        repeat (3) tick();
        check("R2", exp_q.size(), 0, "responses outstanding");
        check("R2", int'(rsp_valid), 0, "rsp_valid idle");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule